// File: doc/BRIEF.md
# Dual-Lane Time-Multiplexed FIR Filter

This block is a 256-tap finite impulse response filter that shares two multipliers across all taps. Each accepted 18-bit signed input sample goes into a circular history buffer of the 256 newest samples, which takes the place of a shift register. Two multiply-accumulate lanes then each cover half of the taps, so a full convolution takes 128 multiply cycles. The two lane totals are added into a 44-bit signed result, which is announced by a single-cycle valid pulse.

Coefficients live in a tap memory with four banks, one filter per bank. A 2-bit select input picks the bank when a computation starts. The memory is filled through a simple write port, where the address is the bank number times 256 plus the tap index. Samples that arrive while a computation is running still enter the history. They do not restart or disturb the result in flight.

Top module: `firFilter`

## Requirements
- R1: After reset, outValid is low, outData is zero and every history entry reads as zero in later results.
- R2: Each result equals the sum over k = 0..255 of h[bank][k]·x[n−k], where x[n] is the sample that started the computation and x[n−k] is the k-th older accepted sample.
- R3: A sample accepted while idle starts a computation. outValid goes high on the 130th rising edge after the accepting edge and stays high for exactly one clock.
- R4: A sample presented while a computation runs is stored in the history and counts in later results. It neither restarts the computation nor changes the result in flight, and it never produces an extra outValid pulse.
- R5: The bank select is sampled on the edge that starts a computation. Changes to it during the computation have no effect on that result.
- R6: The result is exact over the full input range. For example, 256 samples of −131072 against taps of −131072 give 2^42.
- R7: When tapWe is high, a write stores tapData as coefficient h[tapAddr[9:8]][tapAddr[7:0]].
- R8: outData holds its value between result pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inData | input | 18 | Signed input sample |
| filtSel | input | 2 | Coefficient bank select |
| tapWe | input | 1 | Tap memory write enable |
| tapAddr | input | 10 | Tap write address: bank in [9:8], tap index in [7:0] |
| tapData | input | 18 | Signed coefficient to write |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | 44 | Signed filter result |

## Verification
On every cycle, the assertions check four things:
- the result strobe never lasts more than one clock;
- a running computation's counter advances without restarting, even when samples arrive;
- the latched bank stays stable while a computation runs;
- the output register changes only on the final-add strobe.

Only the bench scenarios can show that the arithmetic is right. These compare results against a software convolution for impulses, random data, full-scale data, mid-run sample arrivals and mid-run bank changes. They also confirm that the lane addressing reads exactly the 256 newest samples in the right order.

// File: rtl/firPkg.sv
package firPkg;
  localparam int DataW    = 18;
  localparam int Taps     = 256;
  localparam int Lanes    = 2;
  localparam int Banks    = 4;
  localparam int LaneLen  = Taps / Lanes;
  localparam int PtrW     = $clog2(Taps);
  localparam int IdxW     = $clog2(LaneLen);
  localparam int SelW     = $clog2(Banks);
  localparam int TapAddrW = SelW + PtrW;
  localparam int ProdW    = 2 * DataW;
  localparam int AccW     = ProdW + IdxW;
  localparam int SumW     = AccW + 1;
  localparam int CntW     = IdxW + 1;
  localparam int LastCnt  = LaneLen + 1;

  typedef struct packed {
    logic            start;
    logic            mulEn;
    logic            accEn;
    logic            finEn;
    logic [IdxW-1:0] idx;
  } ctrlT;
endpackage

// File: rtl/firCtrl.sv
module firCtrl
  import firPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output ctrlT ctl
);
  logic            running;
  logic [CntW-1:0] cnt;
  logic            start;

  assign start = inValid & ~running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (cnt == CntW'(LastCnt)) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CntW'(1);
      end
    end
  end

  always_comb begin
    ctl.start = start;
    ctl.mulEn = running && (cnt < CntW'(LaneLen));
    ctl.accEn = running && (cnt >= CntW'(1)) && (cnt <= CntW'(LaneLen));
    ctl.finEn = running && (cnt == CntW'(LastCnt));
    ctl.idx   = cnt[IdxW-1:0];
  end

  // R4
  busy_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && cnt != CntW'(LastCnt)) |=> (running && cnt == CntW'($past(cnt) + CntW'(1))));
endmodule

// File: rtl/firDatapath.sv
module firDatapath
  import firPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlT                       ctl,
  input  logic                       inValid,
  input  logic signed [DataW-1:0]    inData,
  input  logic [SelW-1:0]            filtSel,
  input  logic                       tapWe,
  input  logic [TapAddrW-1:0]        tapAddr,
  input  logic signed [DataW-1:0]    tapData,
  output logic                       outValid,
  output logic signed [SumW-1:0]     outData
);
  logic signed [DataW-1:0] sampleMem [Taps];
  logic signed [DataW-1:0] tapMem [Banks*Taps];
  logic [PtrW-1:0]         wrPtr;
  logic [PtrW-1:0]         basePtr;
  logic [SelW-1:0]         bankQ;
  logic signed [AccW-1:0]  laneAcc [Lanes];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      basePtr <= '0;
      bankQ   <= '0;
      for (int i = 0; i < Taps; i++) sampleMem[i] <= '0;
    end else begin
      if (inValid) begin
        sampleMem[wrPtr] <= inData;
        wrPtr            <= wrPtr + PtrW'(1);
      end
      if (ctl.start) begin
        basePtr <= wrPtr;
        bankQ   <= filtSel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tapWe) tapMem[tapAddr] <= tapData;
  end

  for (genvar l = 0; l < Lanes; l++) begin : gLane
    logic [PtrW-1:0]        sAddr;
    logic [TapAddrW-1:0]    tAddr;
    logic signed [ProdW-1:0] prodQ;
    logic signed [AccW-1:0]  accQ;

    if (l == 0) begin : gUp
      // newest sample first: taps 0..LaneLen-1
      assign sAddr = basePtr - PtrW'(ctl.idx);
      assign tAddr = {bankQ, 1'b0, ctl.idx};
    end else begin : gDown
      // oldest sample first, so late writes only touch slots already read
      assign sAddr = basePtr + PtrW'(ctl.idx) + PtrW'(1);
      assign tAddr = {bankQ, 1'b1, ~ctl.idx};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prodQ <= '0;
        accQ  <= '0;
      end else begin
        if (ctl.mulEn)
          prodQ <= ProdW'(sampleMem[sAddr]) * ProdW'(tapMem[tAddr]);
        if (ctl.start)      accQ <= '0;
        else if (ctl.accEn) accQ <= accQ + AccW'(prodQ);
      end
    end

    assign laneAcc[l] = accQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctl.finEn;
      if (ctl.finEn) outData <= SumW'(laneAcc[0]) + SumW'(laneAcc[1]);
    end
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finEn |=> $stable(outData));

  // R5
  bank_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mulEn || ctl.accEn) |=> $stable(bankQ));
endmodule

// File: rtl/firFilter.sv
module firFilter
  import firPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic signed [17:0]      inData,
  input  logic [1:0]              filtSel,
  input  logic                    tapWe,
  input  logic [9:0]              tapAddr,
  input  logic signed [17:0]      tapData,
  output logic                    outValid,
  output logic signed [43:0]      outData
);
  ctrlT ctl;

  firCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctl     (ctl)
  );

  firDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inValid  (inValid),
    .inData   (inData),
    .filtSel  (filtSel),
    .tapWe    (tapWe),
    .tapAddr  (tapAddr),
    .tapData  (tapData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: tb/firFilter_test.sv
module firFilter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [17:0] inData = '0;
  logic [1:0] filtSel = '0;
  logic tapWe = 1'b0;
  logic [9:0] tapAddr = '0;
  logic signed [17:0] tapData = '0;
  logic outValid;
  logic signed [43:0] outData;

  int passCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  int coef [4][256];
  int hist [256];
  int hp = 0;

  always #10 clk = ~clk;

  firFilter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .filtSel(filtSel), .tapWe(tapWe), .tapAddr(tapAddr), .tapData(tapData),
    .outValid(outValid), .outData(outData)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd18();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  function automatic longint model(int sel);
    longint s = 0;
    for (int k = 0; k < 256; k++)
      s += longint'(coef[sel][k]) * longint'(hist[(hp - 1 - k) & 255]);
    return s;
  endfunction

  task automatic push(int d);
    hist[hp] = d;
    hp = (hp + 1) & 255;
  endtask

  task automatic writeTap(int bank, int k, int v);
    @(negedge clk);
    tapWe = 1'b1;
    tapAddr = 10'(bank * 256 + k);
    tapData = 18'(v);
    coef[bank][k] = v;
  endtask

  // mode 0: plain; 1: samples arrive mid-run; 2: select changes mid-run
  task automatic run(int d, int sel, int mode, int altSel, string req);
    longint expV;
    longint held;
    int n;
    @(negedge clk);
    inValid = 1'b1;
    inData = 18'(d);
    filtSel = 2'(sel);
    push(d);
    expV = model(sel);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (outValid || n > 300) break;
      if (mode == 1 && (n == 1 || n == 2 || n == 64 || n == 129 || n == 130)) begin
        inValid = 1'b1;
        inData = 18'(rnd18());
        push(int'(inData));
      end else begin
        inValid = 1'b0;
      end
      if (mode == 2 && n == 3) filtSel = 2'(altSel);
    end
    inValid = 1'b0;
    chk(n == 131, "R3 latency", n, 131);
    chk(longint'(outData) == expV, req, longint'(outData), expV);
    held = longint'(outData);
    @(negedge clk);
    chk(outValid == 1'b0, "R3 pulse width", longint'(outValid), 0);
    chk(longint'(outData) == held, "R8 hold", longint'(outData), held);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid", longint'(outValid), 0);
    chk(outData == '0, "R1 outData", longint'(outData), 0);

    // R7 fill banks
    for (int k = 0; k < 256; k++) writeTap(0, k, rnd18());
    for (int k = 0; k < 256; k++) writeTap(1, k, k - 128);
    for (int k = 0; k < 256; k++) writeTap(2, k, -131072);
    for (int k = 0; k < 256; k++) writeTap(3, k, rnd18());
    @(negedge clk);
    tapWe = 1'b0;

    // R1 / R7: impulse walks the ramp bank over a zeroed history
    run(1, 1, 0, 0, "R1 R7 impulse tap0");
    run(0, 1, 0, 0, "R7 impulse tap1");
    run(0, 1, 0, 0, "R7 impulse tap2");
    run(5, 1, 0, 0, "R2 two impulses");

    // R2 random data, random banks
    for (int i = 0; i < 24; i++) run(rnd18(), int'($urandom_range(0, 3)), 0, 0, "R2 random");

    // R4 samples during a run
    run(rnd18(), 0, 1, 0, "R4 result in flight");
    seen = 0;
    repeat (140) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, "R4 no restart", seen, 0);
    run(rnd18(), 3, 0, 0, "R4 late samples in history");

    // R5 select change mid-run
    run(rnd18(), 3, 2, 0, "R5 bank latched");
    run(rnd18(), 0, 2, 2, "R5 bank latched");

    // R6 full-scale accumulation
    for (int i = 0; i < 256; i++) run(-131072, 2, 0, 0, "R6 full scale");
    chk(longint'(outData) == (64'sd1 <<< 42), "R6 final", longint'(outData), 64'sd1 <<< 42);
    for (int i = 0; i < 8; i++) run(131071, 2, 0, 0, "R6 mixed sign");

    done = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule